// File: doc/BRIEF.md
# Late-Write Pipelined SRAM with Byte Bypass

This block is a synchronous single-port memory with a late-write protocol. A command (address, select, write enable and four lane enables) is captured on one rising clock edge. For a write, the data word follows on the next edge. A write does not go into the array straight away. It waits in a one-entry holding register together with its address and lane mask. It is committed only when the data of the following write is captured.

A read is captured on one edge and presented from the output register after the next edge. If the read address matches the parked write, every lane that write enabled is taken from the holding register, and the other lanes come from the array. The output bus is never tristated inside the block: a separate enable says when the data is valid. That enable is dropped at once by the asynchronous output-enable input or by the sleep input. While sleep is high, no command is accepted and the stored contents are kept.

Top module: `lw_sram`

## Requirements
- R1: A read (`sel_n`=0, `we_n`=1) captured at edge N appears on `dout`, with `dout_oe` high, from edge N+1 until edge N+2. `dout_oe` is still low between edge N and edge N+1 when the preceding cycle carried no read.
- R2: The data word of a write (`sel_n`=0, `we_n`=0) is taken from `din` on the edge after the one that captured its address, and at no other edge.
- R3: A parked write is written into the array when the data of the next write is captured. After that commit, reading its address returns the committed word even though the holding register now holds another address.
- R4: Lane i is bits [9i+8:9i], and `be_n[i]`=0 enables it. A read whose address equals the parked write's address takes each lane enabled in that write from the holding register, and every other lane from the array.
- R5: A cycle with `sel_n`=1 performs no operation. The array is unchanged, and `dout_oe` is low in the output cycle that follows it.
- R6: `oe_n`=1 forces `dout_oe` low without waiting for a clock edge. Returning `oe_n` to 0 restores it.
- R7: While `sleep`=1, read and write commands are ignored and `dout_oe` is low. Array contents are unchanged when sleep ends.
- R8: Two consecutive reads of the same address leave `dout` unchanged between their output cycles.
- R9: Reset drives `dout_oe` low and discards the parked write. After reset, reading that address returns the value the array held before it.
- R10: A write with all `be_n` high still commits the previously parked write, and it changes no lane of its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Low-power request; blocks commands and output |
| sel_n | input | 1 | Active-low select; high deselects the cycle |
| we_n | input | 1 | Active-low write; high with select gives a read |
| be_n | input | LANES | Active-low lane write enables, one per 9-bit lane |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, presented one cycle after its write command |
| dout | output | LANES*LANE_W | Registered read data |
| dout_oe | output | 1 | High when `dout` should drive the bus |

## Verification
The delicate case is a commit and a bypass read on the same edge. This happens when a write's data is captured, pushing the previous parked write into the array, on the same edge that captures a read of the newly parked address. The vector table places a partial-lane write directly in front of a read of that address, so both events happen at one clock. The expected word is then a lane-by-lane mix of the just-committed array value and the new buffered lanes. The bench also reads the same address again after a later write has moved it into the array, and checks that the mix is unchanged.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    function automatic cmd_e decode_cmd(input logic sleep, input logic sel_n, input logic we_n);
        if (sleep || sel_n) return CMD_IDLE;
        return we_n ? CMD_READ : CMD_WRITE;
    endfunction

endpackage

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l]) begin
                mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/lw_sram_merge.sv
module lw_sram_merge #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              hold_vld,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [LANES-1:0]  hold_mask,
    input  logic [DATA_W-1:0] hold_data,
    output logic [DATA_W-1:0] merged
);

    logic addr_hit;
    assign addr_hit = hold_vld && (hold_addr == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] = (addr_hit && hold_mask[l])
                                          ? hold_data[l*LANE_W +: LANE_W]
                                          : arr_data[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  be_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    typedef struct packed {
        logic              rd;
        logic              wr_pend;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  wmask;
        logic              oe;
        logic [DATA_W-1:0] dout;
        logic              hold_vld;
        logic [ADDR_W-1:0] hold_addr;
        logic [LANES-1:0]  hold_mask;
        logic [DATA_W-1:0] hold_data;
    } state_t;

    state_t s_d, s_q;
    cmd_e   cmd;
    logic   commit_en;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] merged;

    assign cmd       = decode_cmd(sleep, sel_n, we_n);
    assign commit_en = s_q.wr_pend && s_q.hold_vld;

    lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (commit_en),
        .wr_addr (s_q.hold_addr),
        .wr_mask (s_q.hold_mask),
        .wr_data (s_q.hold_data),
        .rd_addr (s_q.addr),
        .rd_data (arr_rd)
    );

    lw_sram_merge #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .rd_addr   (s_q.addr),
        .arr_data  (arr_rd),
        .hold_vld  (s_q.hold_vld),
        .hold_addr (s_q.hold_addr),
        .hold_mask (s_q.hold_mask),
        .hold_data (s_q.hold_data),
        .merged    (merged)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rd      = (cmd == CMD_READ);
        s_d.wr_pend = (cmd == CMD_WRITE);
        if (cmd != CMD_IDLE) begin
            s_d.addr = addr;
        end
        if (cmd == CMD_WRITE) begin
            s_d.wmask = ~be_n;
        end
        s_d.oe = s_q.rd;
        if (s_q.rd) begin
            s_d.dout = merged;
        end
        if (s_q.wr_pend) begin
            s_d.hold_vld  = 1'b1;
            s_d.hold_addr = s_q.addr;
            s_d.hold_mask = s_q.wmask;
            s_d.hold_data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout    = s_q.dout;
    assign dout_oe = s_q.oe && !oe_n && !sleep;

    // R1
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !sel_n && we_n) |=> ##1 s_q.oe);

    // R2
    late_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wr_pend |=> (s_q.hold_vld && s_q.hold_data == $past(din)));

    // R5
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !sleep) |=> ##1 !s_q.oe);

    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_oe);

    // R7
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!s_q.rd && !s_q.wr_pend));

    // R8
    same_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rd && $past(s_q.rd) && s_q.addr == $past(s_q.addr)) |=> $stable(s_q.dout));

endmodule

// File: tb/lw_sram_bench.sv
module lw_sram_bench;
    import lw_sram_pkg::*;

    localparam int AW = 6;
    localparam int DW = 36;

    typedef struct packed {
        cmd_e          op;
        logic [AW-1:0] addr;
        logic [3:0]    be_n;
        logic [DW-1:0] data;
        logic [DW-1:0] exp;
    } vec_t;

    localparam logic [DW-1:0] WA  = {9'h0A1, 9'h0A2, 9'h0A3, 9'h0A4};
    localparam logic [DW-1:0] WB  = {9'h0B1, 9'h0B2, 9'h0B3, 9'h0B4};
    localparam logic [DW-1:0] WC  = {9'h1FF, 9'h1FF, 9'h1FF, 9'h0C4};
    localparam logic [DW-1:0] MX2 = {9'h0B1, 9'h0B2, 9'h0B3, 9'h0C4};
    localparam logic [DW-1:0] WD  = {9'h0D1, 9'h1FF, 9'h0D3, 9'h1FF};
    localparam logic [DW-1:0] MX1 = {9'h0D1, 9'h0A2, 9'h0D3, 9'h0A4};
    localparam logic [DW-1:0] JNK = {4{9'h155}};
    localparam logic [DW-1:0] E1  = {4{9'h0E1}};
    localparam logic [DW-1:0] E2  = {4{9'h0E2}};

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{CMD_WRITE, 6'd1, 4'b0000, WA,  36'd0},  // R2 full write parked
        '{CMD_READ,  6'd1, 4'b1111, 36'd0, WA},   // R4 full bypass
        '{CMD_WRITE, 6'd2, 4'b0000, WB,  36'd0},  // R3 commits addr 1
        '{CMD_READ,  6'd1, 4'b1111, 36'd0, WA},   // R3 from array
        '{CMD_WRITE, 6'd2, 4'b1110, WC,  36'd0},  // lane0 only; commits WB
        '{CMD_READ,  6'd2, 4'b1111, 36'd0, MX2},  // R4 partial bypass, same-edge commit
        '{CMD_READ,  6'd2, 4'b1111, 36'd0, MX2},  // R8 repeat
        '{CMD_WRITE, 6'd3, 4'b1111, JNK, 36'd0},  // R10 empty mask
        '{CMD_READ,  6'd2, 4'b1111, 36'd0, MX2},  // R10 committed mix
        '{CMD_WRITE, 6'd1, 4'b0101, WD,  36'd0},  // lanes 3 and 1
        '{CMD_READ,  6'd1, 4'b1111, 36'd0, MX1},  // R4 alternating lanes
        '{CMD_IDLE,  6'd1, 4'b0000, 36'd0, 36'd0},// R5
        '{CMD_IDLE,  6'd0, 4'b1111, 36'd0, 36'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep = 1'b0;
    logic          sel_n = 1'b1;
    logic          we_n = 1'b1;
    logic [3:0]    be_n = 4'hF;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    lw_sram u_lw_sram (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .we_n(we_n),
        .be_n(be_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input cmd_e op, input logic [AW-1:0] a, input logic [3:0] b);
        sel_n = (op == CMD_IDLE);
        we_n  = (op != CMD_WRITE);
        addr  = a;
        be_n  = b;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        check(dout_oe == 1'b0, "R9 reset oe", {35'd0, dout_oe}, 36'd0);
        check(dout == '0, "R9 reset dout", dout, 36'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV + 2; i++) begin
            tick();
            if (i >= 2) begin
                check(dout_oe == (VEC[i-2].op == CMD_READ), "R1/R5 vector oe",
                      {35'd0, dout_oe}, {35'd0, VEC[i-2].op == CMD_READ});
                if (VEC[i-2].op == CMD_READ) begin
                    check(dout == VEC[i-2].exp, "R4/R3/R8/R10 vector data", dout, VEC[i-2].exp);
                end
            end
            din = (i >= 1 && i <= NV && VEC[i-1].op == CMD_WRITE) ? VEC[i-1].data : '0;
            if (i < NV) drive(VEC[i].op, VEC[i].addr, VEC[i].be_n);
            else        drive(CMD_IDLE, '0, 4'hF);
        end

        // R1 latency and R6 asynchronous output enable
        tick(); drive(CMD_READ, 6'd2, 4'hF);
        tick(); drive(CMD_IDLE, '0, 4'hF);
        check(dout_oe == 1'b0, "R1 not early", {35'd0, dout_oe}, 36'd0);
        tick();
        check(dout_oe == 1'b1 && dout == MX2, "R1 read data", dout, MX2);
        oe_n = 1'b1; #1;
        check(dout_oe == 1'b0, "R6 oe_n high", {35'd0, dout_oe}, 36'd0);
        oe_n = 1'b0; #1;
        check(dout_oe == 1'b1, "R6 oe_n low", {35'd0, dout_oe}, 36'd1);

        // R5 deselected write does nothing
        tick(); sel_n = 1'b1; we_n = 1'b0; addr = 6'd2; be_n = 4'h0;
        tick(); din = JNK; drive(CMD_READ, 6'd2, 4'hF);
        tick(); din = '0; drive(CMD_IDLE, '0, 4'hF);
        check(dout_oe == 1'b0, "R5 deselect oe", {35'd0, dout_oe}, 36'd0);
        tick();
        check(dout == MX2, "R5 array unchanged", dout, MX2);

        // R7 sleep
        tick(); sleep = 1'b1; drive(CMD_WRITE, 6'd2, 4'h0); #1;
        check(dout_oe == 1'b0, "R7 sleep oe", {35'd0, dout_oe}, 36'd0);
        tick(); din = JNK; drive(CMD_READ, 6'd2, 4'hF);
        tick(); din = '0; drive(CMD_IDLE, '0, 4'hF);
        check(dout_oe == 1'b0, "R7 read ignored", {35'd0, dout_oe}, 36'd0);
        tick(); sleep = 1'b0;
        tick(); drive(CMD_READ, 6'd2, 4'hF);
        tick(); drive(CMD_IDLE, '0, 4'hF);
        tick();
        check(dout_oe == 1'b1 && dout == MX2, "R7 contents kept", dout, MX2);

        // R9 reset drops parked write
        tick(); drive(CMD_WRITE, 6'd5, 4'h0);
        tick(); din = E1; drive(CMD_WRITE, 6'd6, 4'h0);
        tick(); din = JNK; drive(CMD_WRITE, 6'd5, 4'h0);
        tick(); din = E2; drive(CMD_IDLE, '0, 4'hF);
        tick(); din = '0; rst_n = 1'b0;
        tick();
        check(dout_oe == 1'b0, "R9 oe after reset", {35'd0, dout_oe}, 36'd0);
        rst_n = 1'b1;
        tick(); drive(CMD_READ, 6'd5, 4'hF);
        tick(); drive(CMD_IDLE, '0, 4'hF);
        tick();
        check(dout == E1, "R9 parked write dropped", dout, E1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule